// File: doc/BRIEF.md
# Double-Buffered Link Attribute Register Bank

This block holds the tuning attributes of a chip-to-chip serial link: the lane counts, the hard-reset detection time, the bit-clock trail length, how often synchronisation sets are sent during training, and the number of training sets to send and expect after leaving each low power state. Software or a remote agent reaches the bank through a small address and data port. Each writable attribute is held twice. The staged copy takes the writes. The live copy drives the link logic through a set of parallel outputs.

The staged values do not reach the live copies when they are written. The link controller gives a one-cycle pulse when the link enters any low power state. On that pulse every staged value is copied into its live copy. Both ends of a link can therefore be reprogrammed while traffic runs, and the new settings all take effect together at the next power-state entry. The two lane-capability attributes are fixed by parameters and cannot be written. A debug select lets the read port return the live copy in place of the staged one.

Top module: `link_attr_bank`

## Requirements
- R1: On a cycle with `rst` high, every staged copy and every live copy loads its reset value. The lane-count attributes reset to log2 of the lane count, with TX_LANES=8 giving 3 and RX_LANES=4 giving 2. The hard-reset time resets to 100, the clock trail to 16 and the sync interval to 32. The training counts reset to 16 in the P1 group, 64 in the P2 group and 1024 in the P3/reset group.
- R2: A write (`wr_en` high at a rising edge) to a writable address loads the low field-width bits of `wr_data` into that attribute's staged copy only. A read returns the value zero-extended to 16 bits.
- R3: When `lp_enter` is high at a rising edge, all live copies take the staged values. The parallel outputs show the new values from the next cycle.
- R4: If a write and `lp_enter` fall on the same edge, the live copy takes the staged value from before the write. The written value stays staged and reaches the live copy at the next `lp_enter`.
- R5: Addresses 0x00 (TX lane capability) and 0x01 (RX lane capability) are read-only, 3 bits wide, and hold log2 of the lane count. Writes to them change nothing.
- R6: A write to an address outside the map changes no attribute. A read from such an address returns 0.
- R7: With `rd_sel_eff`=0, `rd_data` shows the staged copy of the attribute at `addr`. With `rd_sel_eff`=1 it shows the live copy. The read is combinational.
- R8: The address map and the field widths are as follows. The active TX lanes are at 0x02 and the active RX lanes at 0x03, both 3 bits. The hard-reset time is at 0x08 (10 bits). The clock trail is at 0x10 (8 bits) and the sync interval at 0x30 (8 bits). The 16-bit training counts fill 0x20 to 0x2B. These form three groups, P1 then P2 then P3/reset, and each group holds TS1 send, TS1 receive, TS2 send and TS2 receive, in that order.
- R9: `eff_ts_cnt` bits [j*16 +: 16] carry the live copy at address 0x20+j. The other live outputs carry the live copy of the attribute named in their description.
- R10: The live outputs do not change on any edge where `lp_enter` is low, whatever writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the staged copy at `addr` |
| addr | input | 8 | Attribute address for read and write |
| wr_data | input | 16 | Write data; only the low field-width bits are kept |
| rd_sel_eff | input | 1 | 0 reads the staged copy, 1 reads the live copy |
| rd_data | output | 16 | Zero-extended value of the selected copy; 0 when unmapped |
| lp_enter | input | 1 | Pulse marking entry into a low power state; commits all staged values |
| cap_max_tx | output | 3 | TX lane capability (read-only) |
| cap_max_rx | output | 3 | RX lane capability (read-only) |
| eff_active_tx | output | 3 | Live active TX lanes |
| eff_active_rx | output | 3 | Live active RX lanes |
| eff_hard_reset_us | output | 10 | Live hard-reset detection time |
| eff_px_clk_trail | output | 8 | Live bit-clock trail cycles |
| eff_sync_freq | output | 8 | Live sync-set interval |
| eff_ts_cnt | output | 192 | Live training counts, 12 fields of 16 bits |

## Verification
The bench reads all 256 addresses, in both read selections, after reset, after a full-range write sweep and after a commit. These sweeps separate mapped from unmapped decode, writable from read-only fields, and staged from live copies. The write pattern gives each address a different value with high bits set, so any field truncated to the wrong width or placed at the wrong address shows up. The parallel outputs are checked against the same model before and after the commit, which shows that writes alone never reach the live copies. A write that falls on the same edge as a commit, followed by a second commit, tells apart a live copy that takes the old staged value from one that takes the newly written value.

// File: rtl/link_attr_pkg.sv
package link_attr_pkg;

    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 16;
    localparam int LANE_W       = 3;
    localparam int HRST_W       = 10;
    localparam int TRAIL_W      = 8;
    localparam int SYNC_W       = 8;
    localparam int TS_W         = 16;
    localparam int TS_GROUPS    = 3;
    localparam int TS_PER_GROUP = 4;
    localparam int TS_NUM       = TS_GROUPS * TS_PER_GROUP;

    // attribute slot order
    localparam int IDX_CAP_TX  = 0;
    localparam int IDX_CAP_RX  = 1;
    localparam int IDX_ACT_TX  = 2;
    localparam int IDX_ACT_RX  = 3;
    localparam int IDX_HRST    = 4;
    localparam int IDX_TRAIL   = 5;
    localparam int IDX_TS0     = 6;
    localparam int IDX_SYNC    = IDX_TS0 + TS_NUM;
    localparam int NUM_ATTR    = IDX_SYNC + 1;
    localparam int IDX_W       = $clog2(NUM_ATTR);

    localparam logic [ADDR_W-1:0] A_HRST    = 8'h08;
    localparam logic [ADDR_W-1:0] A_TRAIL   = 8'h10;
    localparam logic [ADDR_W-1:0] A_TS_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] A_SYNC    = 8'h30;

    typedef struct packed {
        logic             hit;
        logic             ro;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic int attr_width(int i);
        if (i <= IDX_ACT_RX)   return LANE_W;
        else if (i == IDX_HRST)  return HRST_W;
        else if (i == IDX_TRAIL) return TRAIL_W;
        else if (i == IDX_SYNC)  return SYNC_W;
        else                     return TS_W;
    endfunction

    function automatic logic [ADDR_W-1:0] attr_addr(int i);
        if (i <= IDX_ACT_RX)   return ADDR_W'(i);
        else if (i == IDX_HRST)  return A_HRST;
        else if (i == IDX_TRAIL) return A_TRAIL;
        else if (i == IDX_SYNC)  return A_SYNC;
        else                     return A_TS_BASE + ADDR_W'(i - IDX_TS0);
    endfunction

    function automatic logic attr_is_ro(int i);
        return (i == IDX_CAP_TX) || (i == IDX_CAP_RX);
    endfunction

    function automatic dec_t attr_decode_fn(logic [ADDR_W-1:0] a);
        dec_t d;
        d = '0;
        for (int i = 0; i < NUM_ATTR; i++) begin
            if (attr_addr(i) == a) begin
                d.hit = 1'b1;
                d.ro  = attr_is_ro(i);
                d.idx = IDX_W'(i);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/link_attr_decode.sv
module link_attr_decode
    import link_attr_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output dec_t                dec,
    output logic [NUM_ATTR-1:0] sel
);
    always_comb begin
        dec = attr_decode_fn(addr);
        sel = '0;
        if (dec.hit) sel[dec.idx] = 1'b1;
    end
endmodule

// File: rtl/link_attr_cell.sv
module link_attr_cell #(
    parameter int             W   = 8,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    output logic [W-1:0] shadow,
    output logic [W-1:0] eff
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST;
            eff    <= RST;
        end else begin
            if (wr)     shadow <= wdata;
            if (commit) eff    <= shadow;
        end
    end
endmodule

// File: rtl/link_attr_rdmux.sv
module link_attr_rdmux
    import link_attr_pkg::*;
(
    input  dec_t                             dec,
    input  logic                             sel_eff,
    input  logic [NUM_ATTR-1:0][DATA_W-1:0]  shadow_all,
    input  logic [NUM_ATTR-1:0][DATA_W-1:0]  eff_all,
    output logic [DATA_W-1:0]                rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_ATTR; i++) begin
            if (dec.hit && dec.idx == IDX_W'(i))
                rd_data = sel_eff ? eff_all[i] : shadow_all[i];
        end
    end
endmodule

// File: rtl/link_attr_bank.sv
module link_attr_bank
    import link_attr_pkg::*;
#(
    parameter int TX_LANES    = 8,
    parameter int RX_LANES    = 4,
    parameter int HRST_RST    = 100,
    parameter int TRAIL_RST   = 16,
    parameter int SYNC_RST    = 32,
    parameter int P1_TS_RST   = 16,
    parameter int P2_TS_RST   = 64,
    parameter int P3R_TS_RST  = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_sel_eff,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     lp_enter,
    output logic [LANE_W-1:0]        cap_max_tx,
    output logic [LANE_W-1:0]        cap_max_rx,
    output logic [LANE_W-1:0]        eff_active_tx,
    output logic [LANE_W-1:0]        eff_active_rx,
    output logic [HRST_W-1:0]        eff_hard_reset_us,
    output logic [TRAIL_W-1:0]       eff_px_clk_trail,
    output logic [SYNC_W-1:0]        eff_sync_freq,
    output logic [TS_NUM*TS_W-1:0]   eff_ts_cnt
);
    localparam int TX_LOG2 = $clog2(TX_LANES);
    localparam int RX_LOG2 = $clog2(RX_LANES);

    function automatic logic [DATA_W-1:0] rst_val(int i);
        int g;
        if (i == IDX_CAP_TX || i == IDX_ACT_TX) return DATA_W'(TX_LOG2);
        if (i == IDX_CAP_RX || i == IDX_ACT_RX) return DATA_W'(RX_LOG2);
        if (i == IDX_HRST)  return DATA_W'(HRST_RST);
        if (i == IDX_TRAIL) return DATA_W'(TRAIL_RST);
        if (i == IDX_SYNC)  return DATA_W'(SYNC_RST);
        g = (i - IDX_TS0) / TS_PER_GROUP;
        if (g == 0) return DATA_W'(P1_TS_RST);
        if (g == 1) return DATA_W'(P2_TS_RST);
        return DATA_W'(P3R_TS_RST);
    endfunction

    dec_t                            dec;
    logic [NUM_ATTR-1:0]             sel;
    logic [NUM_ATTR-1:0][DATA_W-1:0] shadow_q;
    logic [NUM_ATTR-1:0][DATA_W-1:0] eff_q;

    link_attr_decode u_dec (
        .addr (addr),
        .dec  (dec),
        .sel  (sel)
    );

    for (genvar i = 0; i < NUM_ATTR; i++) begin : g_attr
        localparam int               W  = attr_width(i);
        localparam logic [DATA_W-1:0] RV = rst_val(i);
        localparam logic [W-1:0]     RW = RV[W-1:0];
        if (attr_is_ro(i)) begin : g_ro
            assign shadow_q[i] = DATA_W'(RW);
            assign eff_q[i]    = DATA_W'(RW);
        end else begin : g_rw
            logic [W-1:0] sh;
            logic [W-1:0] ef;
            link_attr_cell #(.W(W), .RST(RW)) u_cell (
                .clk    (clk),
                .rst    (rst),
                .wr     (wr_en & sel[i]),
                .wdata  (wr_data[W-1:0]),
                .commit (lp_enter),
                .shadow (sh),
                .eff    (ef)
            );
            assign shadow_q[i] = DATA_W'(sh);
            assign eff_q[i]    = DATA_W'(ef);
        end
    end

    link_attr_rdmux u_rd (
        .dec        (dec),
        .sel_eff    (rd_sel_eff),
        .shadow_all (shadow_q),
        .eff_all    (eff_q),
        .rd_data    (rd_data)
    );

    assign cap_max_tx        = eff_q[IDX_CAP_TX][LANE_W-1:0];
    assign cap_max_rx        = eff_q[IDX_CAP_RX][LANE_W-1:0];
    assign eff_active_tx     = eff_q[IDX_ACT_TX][LANE_W-1:0];
    assign eff_active_rx     = eff_q[IDX_ACT_RX][LANE_W-1:0];
    assign eff_hard_reset_us = eff_q[IDX_HRST][HRST_W-1:0];
    assign eff_px_clk_trail  = eff_q[IDX_TRAIL][TRAIL_W-1:0];
    assign eff_sync_freq     = eff_q[IDX_SYNC][SYNC_W-1:0];

    for (genvar j = 0; j < TS_NUM; j++) begin : g_ts
        assign eff_ts_cnt[j*TS_W +: TS_W] = eff_q[IDX_TS0+j][TS_W-1:0];
    end
endmodule

// File: rtl/link_attr_chk.sv
module link_attr_chk
    import link_attr_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic                            lp_enter,
    input logic                            hit,
    input logic [DATA_W-1:0]               rd_data,
    input logic [NUM_ATTR-1:0][DATA_W-1:0] shadow_q,
    input logic [NUM_ATTR-1:0][DATA_W-1:0] eff_q
);
    // R1: both copies agree right after reset
    p_reset_equal_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> shadow_q == eff_q);

    // R3: a commit copies every staged value into the live copy
    p_commit_copy_r3: assert property (@(posedge clk) disable iff (rst)
        lp_enter |=> eff_q == $past(shadow_q));

    // R4: write plus commit on one edge takes the old staged value
    p_same_edge_old_r4: assert property (@(posedge clk) disable iff (rst)
        (lp_enter && wr_en) |=> eff_q == $past(shadow_q));

    // R10: live copies hold without a commit
    p_eff_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !lp_enter |=> $stable(eff_q));

    // R6: unmapped reads give zero
    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !hit |-> rd_data == '0);
endmodule

bind link_attr_bank link_attr_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .lp_enter (lp_enter),
    .hit      (dec.hit),
    .rd_data  (rd_data),
    .shadow_q (shadow_q),
    .eff_q    (eff_q)
);

// File: tb/sim_link_attr_bank.sv
module sim_link_attr_bank;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [15:0]  wr_data = '0;
    logic         rd_sel_eff = 1'b0;
    logic [15:0]  rd_data;
    logic         lp_enter = 1'b0;
    logic [2:0]   cap_max_tx, cap_max_rx, eff_active_tx, eff_active_rx;
    logic [9:0]   eff_hard_reset_us;
    logic [7:0]   eff_px_clk_trail, eff_sync_freq;
    logic [191:0] eff_ts_cnt;

    int tests = 0;
    int fails = 0;
    int mshadow [256];
    int meff    [256];

    always #5 clk = ~clk;

    link_attr_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_sel_eff(rd_sel_eff), .rd_data(rd_data), .lp_enter(lp_enter),
        .cap_max_tx(cap_max_tx), .cap_max_rx(cap_max_rx),
        .eff_active_tx(eff_active_tx), .eff_active_rx(eff_active_rx),
        .eff_hard_reset_us(eff_hard_reset_us), .eff_px_clk_trail(eff_px_clk_trail),
        .eff_sync_freq(eff_sync_freq), .eff_ts_cnt(eff_ts_cnt)
    );

    function automatic int m_width(int a);
        if (a < 4) return 3;
        if (a == 'h08) return 10;
        if (a == 'h10 || a == 'h30) return 8;
        if (a >= 'h20 && a <= 'h2b) return 16;
        return 0;
    endfunction

    function automatic bit m_ro(int a);
        return a < 2;
    endfunction

    function automatic int m_rst(int a);
        if (a == 0 || a == 2) return 3;
        if (a == 1 || a == 3) return 2;
        if (a == 'h08) return 100;
        if (a == 'h10) return 16;
        if (a == 'h30) return 32;
        if (a >= 'h20 && a <= 'h23) return 16;
        if (a >= 'h24 && a <= 'h27) return 64;
        if (a >= 'h28 && a <= 'h2b) return 1024;
        return 0;
    endfunction

    function automatic int pat(int a);
        return (a * 40503 + 4660) & 'hffff;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 256; a++) begin
            mshadow[a] = m_rst(a);
            meff[a]    = m_rst(a);
        end
    endtask

    task automatic do_write(int a, int d, bit c);
        @(negedge clk);
        addr = 8'(a); wr_data = 16'(d); wr_en = 1'b1; lp_enter = c;
        @(negedge clk);
        wr_en = 1'b0; lp_enter = 1'b0;
        if (c) for (int k = 0; k < 256; k++) meff[k] = mshadow[k];
        if (m_width(a) != 0 && !m_ro(a))
            mshadow[a] = d & ((1 << m_width(a)) - 1);
    endtask

    task automatic do_commit();
        @(negedge clk);
        lp_enter = 1'b1;
        @(negedge clk);
        lp_enter = 1'b0;
        for (int k = 0; k < 256; k++) meff[k] = mshadow[k];
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 256; a++) begin
            for (int s = 0; s < 2; s++) begin
                int exp;
                addr = 8'(a); rd_sel_eff = s[0];
                #1;
                exp = (m_width(a) == 0) ? 0 : (s == 1 ? meff[a] : mshadow[a]);
                chk(rd_data == 16'(exp), $sformatf("%s R7 addr=0x%0h sel=%0d", tag, a, s),
                    int'(rd_data), exp);
            end
        end
        rd_sel_eff = 1'b0;
    endtask

    task automatic check_outputs(string tag);
        chk(cap_max_tx == 3'(meff[0]), {tag, " R5 cap_tx"}, int'(cap_max_tx), meff[0]);
        chk(cap_max_rx == 3'(meff[1]), {tag, " R5 cap_rx"}, int'(cap_max_rx), meff[1]);
        chk(eff_active_tx == 3'(meff[2]), {tag, " R9 act_tx"}, int'(eff_active_tx), meff[2]);
        chk(eff_active_rx == 3'(meff[3]), {tag, " R9 act_rx"}, int'(eff_active_rx), meff[3]);
        chk(eff_hard_reset_us == 10'(meff['h08]), {tag, " R9 hrst"}, int'(eff_hard_reset_us), meff['h08]);
        chk(eff_px_clk_trail == 8'(meff['h10]), {tag, " R9 trail"}, int'(eff_px_clk_trail), meff['h10]);
        chk(eff_sync_freq == 8'(meff['h30]), {tag, " R9 sync"}, int'(eff_sync_freq), meff['h30]);
        for (int j = 0; j < 12; j++)
            chk(eff_ts_cnt[j*16 +: 16] == 16'(meff['h20 + j]),
                $sformatf("%s R9 R8 ts%0d", tag, j), int'(eff_ts_cnt[j*16 +: 16]), meff['h20 + j]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 R8 reset state through both copies and all outputs
        sweep("R1 R8 R6 after reset");
        check_outputs("R1 reset");

        // R2 R5 R6: write every address, only staged copies of mapped writable fields move
        for (int a = 0; a < 256; a++) do_write(a, pat(a), 1'b0);
        #1;
        sweep("R2 R5 R6 after writes");
        check_outputs("R10 no commit");

        // R3: commit moves everything
        do_commit();
        #1;
        check_outputs("R3 after commit");
        sweep("R3 after commit");

        // R4: write and commit on the same edge
        do_write('h21, 'h1234, 1'b0);
        do_write('h21, 'habcd, 1'b1);
        #1;
        check_outputs("R4 same edge");
        addr = 8'h21; rd_sel_eff = 1'b1; #1;
        chk(rd_data == 16'h1234, "R4 live holds old staged", int'(rd_data), 'h1234);
        rd_sel_eff = 1'b0; #1;
        chk(rd_data == 16'habcd, "R4 new value staged", int'(rd_data), 'habcd);
        do_commit();
        #1;
        check_outputs("R4 second commit");

        // R10: writes without commit leave live outputs
        do_write('h02, 7, 1'b0);
        do_write('h08, 'h3ff, 1'b0);
        #1;
        check_outputs("R10 hold");

        // R1: reset again restores both copies
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        #1;
        check_outputs("R1 re-reset");
        sweep("R1 re-reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule